// File: doc/BRIEF.md
# Framed Serial Deserializer with Lock

This block recovers word-aligned 10-bit parallel data from a serial bit stream that has already been retimed to a bit-rate clock. Each serial frame takes twelve bit times. A marker bit of value 1 opens the frame, ten payload bits follow, and a marker bit of value 0 closes it. The block slides its frame boundary until the two markers line up. After a run of well-framed frames it declares alignment on an active-low lock pin. It then produces a recovered word clock with a period of twelve bit clocks and presents each payload on a parallel bus.

A reference-clock enable input paces a settling counter that models PLL settling after power-up. No frame search starts until that counter has expired. A strobe-select pin chooses which edge of the recovered word clock the consumer samples on, and the data is launched on the other edge. Power-down, output-enable and the high-impedance state are modelled with one drive-enable flag per output group (data, word clock, lock). The parallel side is a stream with no ready input: a serial link cannot be stalled. `word_valid` pulses once per delivered word, and the consumer must take every word.

Top module: `frame_deser`

## Requirements
- R1: A frame is a 1 marker, then payload bits 0 to 9 in that order, then a 0 marker. Payload bit i of a frame is presented on `word_data[i]`, and successive words appear in the order they were sent.
- R2: After `pwr_up` rises, `lock_n` stays high until 2048 `ref_tick` pulses have been counted. With sync frames present, it falls no later than 2048+42 pulses after the rise.
- R3: When the block is powered and settled but unaligned, `lock_n` falls within 42 `ref_tick` periods of valid frames starting at an arbitrary bit offset.
- R4: Alignment needs 4 consecutive frames with correct markers at one boundary. While locked, one bad frame is tolerated, and lock is dropped after 2 consecutive frames with a marker error.
- R5: After `lock_n` falls, `data_oe` stays low and `word_data` reads zero at the first selected strobe edge of `word_clk`. Valid data is driven from the second selected strobe edge on.
- R6: With `rise_sel` = 1 the consumer samples on the rising edge of `word_clk`, and with `rise_sel` = 0 on the falling edge. `word_data` never changes across a selected strobe edge.
- R7: While locked, `word_clk` has a period of 12 bit clocks and is high for 6 of them.
- R8: `out_en` low forces `data_oe` and `wclk_oe` low and suppresses `word_valid`. `lock_oe` stays high and lock is kept. Data resumes at once when `out_en` returns high.
- R9: `pwr_up` low forces `data_oe`, `wclk_oe` and `lock_oe` low, and it clears alignment and the settling counter.
- R10: `word_valid` is a one-cycle pulse issued once per word launched while data is valid, so exactly one pulse falls between consecutive selected strobe edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | High = operate, low = power-down |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| ser_in | input | 1 | Serial data, one bit per clock |
| out_en | input | 1 | Enables the data and word-clock outputs |
| rise_sel | input | 1 | 1 = sample on rising edge of word_clk, 0 = falling |
| word_data | output | 10 | Recovered parallel word |
| word_valid | output | 1 | Pulse marking a newly launched word |
| data_oe | output | 1 | Drive enable for word_data |
| word_clk | output | 1 | Recovered word-rate clock |
| wclk_oe | output | 1 | Drive enable for word_clk |
| lock_n | output | 1 | Active-low alignment indicator |
| lock_oe | output | 1 | Drive enable for lock_n |

## Verification
A wrong frame boundary or a corrupt slip counter shows up first on `lock_n`. It either stays high past the 42-period acquisition limit, or it falls too early and the words then appear out of order or bit-rotated on `word_data` within one word period. A fault in the edge-counting state after lock shows up within two word-clock periods: `data_oe` rises one strobe too early or too late, or `word_data` moves across a sampling edge. A settle counter that does not restart on power-down lets lock return after only a few reference periods, well short of 2048.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam logic START_BIT = 1'b1;
  localparam logic END_BIT   = 1'b0;

  typedef enum logic {
    AL_HUNT,
    AL_TRACK
  } align_state_e;
endpackage

// File: rtl/fd_settle.sv
module fd_settle #(
  parameter  int SETTLE_TICKS = 2048,
  localparam int CNT_W = $clog2(SETTLE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_up,
  input  logic ref_tick,
  output logic settled
);
  logic [CNT_W-1:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      settled  <= 1'b0;
    end else if (!pwr_up) begin
      tick_cnt <= '0;
      settled  <= 1'b0;
    end else if (ref_tick && !settled) begin
      if (tick_cnt == CNT_W'(SETTLE_TICKS - 1)) settled <= 1'b1;
      else tick_cnt <= tick_cnt + 1'b1;
    end
  end

  AST_SETTLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(ref_tick && pwr_up)); // R2
endmodule

// File: rtl/fd_align.sv
module fd_align
  import fd_pkg::*;
#(
  parameter  int PAY_W       = 10,
  parameter  int ACQ_FRAMES  = 4,
  parameter  int LOSS_FRAMES = 2,
  localparam int FRAME       = PAY_W + 2,
  localparam int PH_W        = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ser_in,
  output logic [PH_W-1:0]  ph,
  output logic             frame_end,
  output logic             locked,
  output logic [PAY_W-1:0] payload
);
  localparam int ACQ_W = $clog2(ACQ_FRAMES + 1);
  localparam int ERR_W = $clog2(LOSS_FRAMES + 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(FRAME - 1);

  align_state_e     state;
  logic [FRAME-2:0] sr;
  logic [FRAME-1:0] win;
  logic             good;
  logic [ACQ_W-1:0] acq_cnt;
  logic [ERR_W-1:0] err_cnt;

  // oldest bit sits at the top of the window
  assign win       = {sr, ser_in};
  assign good      = (win[FRAME-1] == START_BIT) && (win[0] == END_BIT);
  assign frame_end = (ph == LAST);
  assign locked    = (state == AL_TRACK);

  for (genvar i = 0; i < PAY_W; i++) begin : g_pay
    assign payload[i] = win[FRAME-2-i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= AL_HUNT;
      sr      <= '0;
      ph      <= LAST;
      acq_cnt <= '0;
      err_cnt <= '0;
    end else if (!run) begin
      state   <= AL_HUNT;
      sr      <= '0;
      ph      <= LAST;
      acq_cnt <= '0;
      err_cnt <= '0;
    end else begin
      sr <= win[FRAME-2:0];
      if (!frame_end) begin
        ph <= ph + 1'b1;
      end else if (state == AL_HUNT) begin
        if (good) begin
          ph <= '0;
          if (acq_cnt == ACQ_W'(ACQ_FRAMES - 1)) begin
            state   <= AL_TRACK;
            acq_cnt <= '0;
            err_cnt <= '0;
          end else begin
            acq_cnt <= acq_cnt + 1'b1;
          end
        end else begin
          acq_cnt <= '0;            // slip: re-test one bit later
        end
      end else begin
        ph <= '0;
        if (good) begin
          err_cnt <= '0;
        end else if (err_cnt == ERR_W'(LOSS_FRAMES - 1)) begin
          state   <= AL_HUNT;
          err_cnt <= '0;
          ph      <= LAST;
        end else begin
          err_cnt <= err_cnt + 1'b1;
        end
      end
    end
  end

  AST_LOCK_ON_GOOD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(good && frame_end)); // R4
  AST_DROP_ON_BAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && $past(run)) |-> $past(frame_end && !good)); // R4
  AST_HUNT_SLIPS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (!locked && frame_end && !good) |=> frame_end); // R3
endmodule

// File: rtl/fd_outstage.sv
module fd_outstage #(
  parameter  int PAY_W = 10,
  parameter  int FRAME = PAY_W + 2,
  localparam int PH_W  = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             locked,
  input  logic [PH_W-1:0]  ph,
  input  logic             frame_end,
  input  logic [PAY_W-1:0] payload,
  input  logic             rise_sel,
  output logic             wclk,
  output logic [PAY_W-1:0] dout,
  output logic             data_ok,
  output logic             word_valid
);
  localparam logic [PH_W-1:0] HALF = PH_W'(FRAME / 2);

  logic [PAY_W-1:0] cap;
  logic             seen_strobe;
  logic             data_ok_q;
  logic             wclk_q;
  logic             strobe_cyc;
  logic             launch_cyc;

  // wclk_q changes at the edge that closes the phase-0 and phase-HALF cycles
  assign strobe_cyc = locked && (rise_sel ? (ph == '0) : (ph == HALF));
  assign launch_cyc = locked && (rise_sel ? (ph == HALF) : (ph == '0));
  assign wclk       = wclk_q;
  assign data_ok    = data_ok_q && locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q      <= 1'b0;
      cap         <= '0;
      dout        <= '0;
      seen_strobe <= 1'b0;
      data_ok_q   <= 1'b0;
      word_valid  <= 1'b0;
    end else begin
      wclk_q <= (ph < HALF);
      if (frame_end) cap <= payload;
      if (!locked) begin
        dout        <= '0;
        seen_strobe <= 1'b0;
        data_ok_q   <= 1'b0;
        word_valid  <= 1'b0;
      end else begin
        word_valid <= 1'b0;
        if (strobe_cyc) seen_strobe <= 1'b1;
        if (launch_cyc) begin
          dout <= cap;
          if (seen_strobe) begin
            data_ok_q  <= 1'b1;
            word_valid <= 1'b1;
          end
        end
      end
    end
  end

  AST_HOLD_ACROSS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && strobe_cyc) |=> $stable(dout)); // R6
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ok_q) |-> $past(seen_strobe)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R10
endmodule

// File: rtl/frame_deser.sv
module frame_deser #(
  parameter int PAY_W        = 10,
  parameter int SETTLE_TICKS = 2048,
  parameter int ACQ_FRAMES   = 4,
  parameter int LOSS_FRAMES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_up,
  input  logic             ref_tick,
  input  logic             ser_in,
  input  logic             out_en,
  input  logic             rise_sel,
  output logic [PAY_W-1:0] word_data,
  output logic             word_valid,
  output logic             data_oe,
  output logic             word_clk,
  output logic             wclk_oe,
  output logic             lock_n,
  output logic             lock_oe
);
  localparam int FRAME = PAY_W + 2;
  localparam int PH_W  = $clog2(FRAME);

  logic             settled;
  logic             run;
  logic [PH_W-1:0]  ph;
  logic             frame_end;
  logic             locked;
  logic [PAY_W-1:0] payload;
  logic             wclk;
  logic [PAY_W-1:0] dout;
  logic             data_ok;
  logic             wv;

  assign run = pwr_up && settled;

  fd_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .ref_tick(ref_tick), .settled(settled)
  );

  fd_align #(.PAY_W(PAY_W), .ACQ_FRAMES(ACQ_FRAMES), .LOSS_FRAMES(LOSS_FRAMES)) u_align (
    .clk(clk), .rst_n(rst_n), .run(run), .ser_in(ser_in), .ph(ph),
    .frame_end(frame_end), .locked(locked), .payload(payload)
  );

  fd_outstage #(.PAY_W(PAY_W), .FRAME(FRAME)) u_out (
    .clk(clk), .rst_n(rst_n), .locked(locked), .ph(ph), .frame_end(frame_end),
    .payload(payload), .rise_sel(rise_sel), .wclk(wclk), .dout(dout),
    .data_ok(data_ok), .word_valid(wv)
  );

  assign data_oe    = pwr_up && out_en && data_ok;
  assign word_data  = data_oe ? dout : '0;
  assign word_valid = wv && out_en;
  assign word_clk   = wclk;
  assign wclk_oe    = pwr_up && out_en;
  assign lock_n     = !locked;
  assign lock_oe    = pwr_up;
endmodule

// File: tb/frame_deser_tb.sv
`timescale 1ns/1ps
module frame_deser_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, pwr_up, ref_tick, ser_in, out_en, rise_sel;
  logic [9:0] word_data;
  logic       word_valid, data_oe, word_clk, wclk_oe, lock_n, lock_oe;

  always #4 clk = ~clk;

  frame_deser dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .ref_tick(ref_tick), .ser_in(ser_in),
    .out_en(out_en), .rise_sel(rise_sel), .word_data(word_data), .word_valid(word_valid),
    .data_oe(data_oe), .word_clk(word_clk), .wclk_oe(wclk_oe), .lock_n(lock_n),
    .lock_oe(lock_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference enable: one pulse per 12 bit clocks
  int ticks = 0;
  initial begin
    ref_tick = 1'b0;
    forever begin
      repeat (11) @(negedge clk);
      ref_tick = 1'b1;
      ticks++;
      @(negedge clk);
      ref_tick = 1'b0;
    end
  end

  // serial source: 0 idle, 1 sync frames, 2 data frames
  int tx_mode  = 0;
  int bad_pend = 0;
  int tx_idx   = 0;
  int base     = 0;
  int sent [2048];
  initial begin
    ser_in = 1'b0;
    forever begin
      if (tx_mode == 0) begin
        ser_in = 1'b0;
        @(negedge clk);
      end else begin : frm
        logic [9:0] w;
        logic       endb;
        if (tx_mode == 1) w = 10'h01F;
        else begin
          w = 10'(512 | ((tx_idx * 389 + base) % 512));
          sent[tx_idx % 2048] = int'(w);
          tx_idx++;
        end
        endb = 1'b0;
        if (bad_pend > 0) begin
          bad_pend--;
          endb = 1'b1;
        end
        ser_in = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
          ser_in = w[i];
          @(negedge clk);
        end
        ser_in = endb;
        @(negedge clk);
      end
    end
  end

  task automatic check_stream(input bit rsel, input int nstr);
    bit         pw, rise, fall;
    int         ns = 0, nv = 0, k = -1, cyc = 0, lastrise = -1;
    logic [9:0] prevw, w;
    pw    = word_clk;
    prevw = word_data;
    while (ns < nstr) begin
      @(negedge clk);
      cyc++;
      if (word_valid) nv++;
      rise = word_clk && !pw;
      fall = !word_clk && pw;
      if (rise) begin
        if (lastrise >= 0) chk(cyc - lastrise == 12, "R7 word clock period", cyc - lastrise, 12);
        lastrise = cyc;
      end
      if (fall && lastrise >= 0) chk(cyc - lastrise == 6, "R7 word clock high time", cyc - lastrise, 6);
      if (rsel ? rise : fall) begin
        ns++;
        w = word_data;
        if (ns == 1) begin
          chk(!data_oe && word_data == 10'h0, "R5 data hidden at first strobe", int'(data_oe), 0);
        end else begin
          if (ns == 2) chk(data_oe, "R5 data valid at second strobe", int'(data_oe), 1);
          chk(w == prevw, "R6 word stable across selected edge", int'(w), int'(prevw));
          chk(nv == 1, "R10 one valid pulse per word", nv, 1);
          if (k < 0) begin
            if (w != 10'h01F) begin
              for (int j = 1; j <= 4; j++)
                if (k < 0 && tx_idx - j >= 0 && sent[(tx_idx - j) % 2048] == int'(w)) k = tx_idx - j;
              chk(k >= 0, "R1 first data word found", int'(w), sent[(tx_idx - 1) % 2048]);
            end
          end else begin
            k++;
            chk(int'(w) == sent[k % 2048], "R1 word order and bit mapping", int'(w), sent[k % 2048]);
          end
        end
        nv = 0;
      end
      pw    = word_clk;
      prevw = word_data;
    end
    chk(k >= 0, "R1 data words delivered", k, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_up = 1'b0; out_en = 1'b1; rise_sel = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!lock_oe && !data_oe && !wclk_oe, "R9 outputs disabled while powered down",
        int'({lock_oe, data_oe, wclk_oe}), 0);
    chk(word_data == 10'h0, "R5 no data after reset", int'(word_data), 0);
  endtask

  task automatic t_powerup(input bit rsel);
    int t0, tk;
    bit got = 0;
    rise_sel = rsel;
    tx_mode  = 1;
    repeat ($urandom_range(0, 11)) @(negedge clk);
    pwr_up = 1'b1;
    t0 = ticks;
    for (int c = 0; c < 40000 && !got; c++) begin
      @(negedge clk);
      if (lock_oe && !lock_n) got = 1;
    end
    tk = ticks - t0;
    chk(got && tk >= 2048, "R2 lock not before settle count", tk, 2048);
    chk(got && tk <= 2090, "R2 lock within settle plus acquisition", tk, 2090);
    tx_mode = 2;
    check_stream(rsel, 40);
  endtask

  task automatic t_loss();
    bad_pend = 1;
    wait (bad_pend == 0);
    repeat (13) @(negedge clk);
    chk(!lock_n, "R4 single bad frame keeps lock", int'(lock_n), 0);
    repeat (30) @(negedge clk);
    bad_pend = 2;
    wait (bad_pend == 0);
    repeat (13) @(negedge clk);
    chk(lock_n, "R4 two bad frames drop lock", int'(lock_n), 1);
  endtask

  task automatic t_reacquire();
    int t0;
    bit got = 0;
    tx_mode = 0;
    for (int c = 0; c < 400 && !lock_n; c++) @(negedge clk);
    chk(lock_n, "R4 idle line drops lock", int'(lock_n), 1);
    repeat (30 + $urandom_range(0, 11)) @(negedge clk);
    t0 = ticks;
    tx_mode = 1;
    for (int c = 0; c < 2000 && !got; c++) begin
      @(negedge clk);
      if (!lock_n) got = 1;
    end
    chk(got && ticks - t0 <= 42, "R3 reacquire within 42 reference periods", ticks - t0, 42);
    tx_mode = 2;
  endtask

  task automatic t_oe();
    int nv = 0;
    repeat (48) @(negedge clk);
    chk(data_oe, "R8 data driven before disable", int'(data_oe), 1);
    out_en = 1'b0;
    @(negedge clk);
    chk(!data_oe && !wclk_oe, "R8 data and clock disabled", int'({data_oe, wclk_oe}), 0);
    chk(lock_oe && !lock_n, "R8 lock still driven and held", int'({lock_oe, lock_n}), 2);
    repeat (40) begin
      @(negedge clk);
      if (word_valid) nv++;
    end
    chk(nv == 0, "R8 no valid pulses while disabled", nv, 0);
    chk(!lock_n, "R8 alignment kept while disabled", int'(lock_n), 0);
    out_en = 1'b1;
    @(negedge clk);
    chk(data_oe, "R8 data resumes without relock", int'(data_oe), 1);
  endtask

  task automatic t_pwrdown();
    pwr_up = 1'b0;
    @(negedge clk);
    chk(!lock_oe && !wclk_oe && !data_oe, "R9 power-down disables all outputs",
        int'({lock_oe, wclk_oe, data_oe}), 0);
    repeat (20) @(negedge clk);
    chk(!lock_oe, "R9 lock pin stays disabled", int'(lock_oe), 0);
    t_powerup(1'b0);   // settle bound proves the counter restarted (R9)
  endtask

  initial begin
    base = int'($urandom_range(0, 511));
    t_reset();
    t_powerup(1'b1);
    t_loss();
    t_reacquire();
    t_oe();
    t_pwrdown();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule